// File: doc/BRIEF.md
# I2C Master Command FIFO and Status Front End

This block is the register side of a command-driven I2C master. Software talks to it through a plain 32-bit register port: it queues command words into a transmit FIFO, drains received bytes from a receive FIFO, sets the FIFO watermarks and the interrupt mask, and reads back status. A separate bus engine takes command words from the transmit FIFO, pushes received bytes into the receive FIFO, and reports bus events. Stop done, NACK and arbitration loss arrive as one-cycle pulses. Master busy and bus busy arrive as levels.

The block does three things with this state. It derives two live request flags from the FIFO fill levels against their watermarks. It keeps the three bus events as sticky flags that software clears by writing ones. It drives one level interrupt line from the status word masked by the enable register. A read of the receive data word carries its own empty marker, so software can drain the FIFO in a loop without a separate status read.

The register map is: 0x00 capability word (read only), 0x04 control, 0x08 status, 0x0C interrupt enable, 0x10 watermarks, 0x14 fill levels, 0x18 transmit command (write only), 0x1C receive data (read only).

Top module: `i2c_cmd_regfront`

## Requirements
- R1: The capability word at 0x00 reads the transmit FIFO depth exponent `TX_AW` in bits 3:0 and the receive FIFO depth exponent `RX_AW` in bits 11:8. All other bits read as zero.
- R2: After reset, the following values hold:
  - the status word reads 0x0000_0001 (only the transmit request is set, because an empty FIFO is at or below the zero watermark);
  - the fill levels, the watermarks and the interrupt enable all read zero;
  - `irq` is low.
- R3: A write to 0x18 pushes bits 10:0 of the write data (command in 10:8, byte in 7:0) into the transmit FIFO. The engine sees the words on `eng_tx_cmd` in write order, with `eng_tx_valid` high while the FIFO holds data. `eng_tx_pop` removes the head word. A write to a full FIFO is dropped.
- R4: Status bit 0 (transmit request) is high exactly while the transmit fill level is at or below the transmit watermark. That watermark is held in bits 7:0 of 0x10.
- R5: A read of 0x1C returns the head byte in bits 7:0 and pops it. When the receive FIFO is empty, the read returns bit 14 set with bits 7:0 zero, and it pops nothing.
- R6: Status bit 1 (receive ready) is high exactly while the receive fill level is above the receive watermark. That watermark is held in bits 23:16 of 0x10. The fill levels at 0x14 report the transmit count in bits 7:0 and the receive count in bits 23:16.
- R7: The stop, NACK and arbitration pulses set sticky status bits 9, 10 and 11. Writing a one to any of these bits at 0x08 clears it, and writing a zero leaves it set. When a pulse and a clear arrive in the same cycle, the pulse wins.
- R8: Status bits 24 and 25 follow the master busy and bus busy levels, one clock later.
- R9: `irq` is high exactly while some status bit is set whose bit in the enable register at 0x0C is set. The enable register reads back its implemented bits 0, 1, 9, 10, 11, 24 and 25.
- R10: Writing control bit 8 empties the transmit FIFO, and writing control bit 9 empties the receive FIFO. Both bits read back as zero.
- R11: Control bit 0 drives `master_en`. While control bit 1 is set, the following hold:
  - both FIFOs are held empty;
  - the sticky flags are held clear;
  - the watermarks are held at zero;
  - transmit writes are dropped.
- R12: A byte that the engine pushes into a full receive FIFO is dropped, and the bytes already stored are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops receive data) |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, valid in the cycle of the strobe |
| master_en | output | 1 | Master enable to the bus engine |
| eng_tx_valid | output | 1 | Transmit FIFO holds a command word |
| eng_tx_cmd | output | 11 | Head command word |
| eng_tx_pop | input | 1 | Engine consumes the head word |
| eng_rx_push | input | 1 | Engine delivers a received byte |
| eng_rx_byte | input | 8 | Received byte |
| eng_stop_evt | input | 1 | Stop completed pulse |
| eng_nack_evt | input | 1 | NACK seen pulse |
| eng_arb_evt | input | 1 | Arbitration lost pulse |
| eng_mbusy | input | 1 | Master busy level |
| eng_bbusy | input | 1 | Bus busy level |
| irq | output | 1 | Level interrupt |

## Verification
The hardest cases to reach are the edges of the two FIFOs: a write or engine push that arrives while the FIFO is full, and a read of receive data while the FIFO is empty. Neither can be seen directly, because a dropped item leaves no trace on its own. The stimulus therefore overfills each FIFO by one item with a distinctive value. It then drains the FIFO through the normal path and checks the drained stream against the scoreboard, which holds only the items that should have been accepted. A receive read at the empty edge is followed by a push and a read, which shows that nothing was popped. The reset bit is held across a transmit write to show that the write is dropped.

// File: rtl/i2cf_pkg.sv
package i2cf_pkg;
    // register byte addresses
    localparam logic [7:0] ADR_CAPS  = 8'h00;
    localparam logic [7:0] ADR_CTRL  = 8'h04;
    localparam logic [7:0] ADR_STAT  = 8'h08;
    localparam logic [7:0] ADR_IEN   = 8'h0C;
    localparam logic [7:0] ADR_WMARK = 8'h10;
    localparam logic [7:0] ADR_FILL  = 8'h14;
    localparam logic [7:0] ADR_TXCMD = 8'h18;
    localparam logic [7:0] ADR_RXDAT = 8'h1C;

    // control bits
    localparam int CT_EN   = 0;
    localparam int CT_SRST = 1;
    localparam int CT_TXFL = 8;
    localparam int CT_RXFL = 9;

    // status bits
    localparam int ST_TXREQ = 0;
    localparam int ST_RXRDY = 1;
    localparam int ST_STOP  = 9;
    localparam int ST_NACK  = 10;
    localparam int ST_ARB   = 11;
    localparam int ST_MBUSY = 24;
    localparam int ST_BBUSY = 25;

    localparam int RX_EMPTY_BIT = 14;
    localparam logic [31:0] IEN_MASK = 32'h0300_0E03;

    localparam int CMD_W = 11;
    localparam int NUM_EVT = 3;
endpackage

// File: rtl/i2cf_fifo.sv
module i2cf_fifo #(
    parameter int W  = 8,
    parameter int AW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic          pop,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata,
    output logic [AW:0]   count,
    output logic          full,
    output logic          empty
);
    localparam int DEPTH = 1 << AW;
    localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wptr;
        logic [AW-1:0]           rptr;
        logic [AW:0]             cnt;
    } fifo_st_t;

    fifo_st_t s_d, s_q;
    logic do_push, do_pop;

    always_comb begin
        s_d     = s_q;
        do_push = push && (s_q.cnt != FULL_CNT);
        do_pop  = pop && (s_q.cnt != '0);
        if (flush) begin
            s_d.wptr = '0;
            s_d.rptr = '0;
            s_d.cnt  = '0;
        end else begin
            if (do_push) begin
                s_d.mem[s_q.wptr] = wdata;
                s_d.wptr          = s_q.wptr + 1'b1;
            end
            if (do_pop) begin
                s_d.rptr = s_q.rptr + 1'b1;
            end
            s_d.cnt = s_q.cnt + {{AW{1'b0}}, do_push} - {{AW{1'b0}}, do_pop};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rdata = s_q.mem[s_q.rptr];
    assign count = s_q.cnt;
    assign full  = (s_q.cnt == FULL_CNT);
    assign empty = (s_q.cnt == '0);

    p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);
    p_full_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !flush) |=> full);
    p_flush_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);
endmodule

// File: rtl/i2cf_events.sv
module i2cf_events #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wipe,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flags
);
    typedef struct packed {
        logic [N-1:0] flg;
    } evt_st_t;

    evt_st_t e_d, e_q;

    always_comb begin
        e_d = e_q;
        if (wipe) e_d.flg = '0;
        else      e_d.flg = (e_q.flg & ~clr) | set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '0;
        else        e_q <= e_d;
    end

    assign flags = e_q.flg;

    for (genvar i = 0; i < N; i++) begin : g_chk
        p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (set[i] && !wipe) |=> flags[i]);
        p_sticky_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[i] && !clr[i] && !wipe) |=> flags[i]);
        p_wipe_r11: assert property (@(posedge clk) disable iff (!rst_n)
            wipe |=> !flags[i]);
    end
endmodule

// File: rtl/i2c_cmd_regfront.sv
module i2c_cmd_regfront
    import i2cf_pkg::*;
#(
    parameter int TX_AW = 2,
    parameter int RX_AW = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [7:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              master_en,
    output logic              eng_tx_valid,
    output logic [CMD_W-1:0]  eng_tx_cmd,
    input  logic              eng_tx_pop,
    input  logic              eng_rx_push,
    input  logic [7:0]        eng_rx_byte,
    input  logic              eng_stop_evt,
    input  logic              eng_nack_evt,
    input  logic              eng_arb_evt,
    input  logic              eng_mbusy,
    input  logic              eng_bbusy,
    output logic              irq
);
    localparam int TX_CW = TX_AW + 1;
    localparam int RX_CW = RX_AW + 1;

    typedef struct packed {
        logic        en;
        logic        srst;
        logic [31:0] ien;
        logic [7:0]  tx_wm;
        logic [7:0]  rx_wm;
        logic        mbusy;
        logic        bbusy;
    } regs_t;

    regs_t r_d, r_q;

    logic wr_ctrl, wr_stat, wr_ien, wr_wm, wr_tx, rd_rx;
    logic tx_flush, rx_flush, tx_push;
    logic [TX_CW-1:0] tx_count;
    logic [RX_CW-1:0] rx_count;
    logic             tx_full, tx_empty, rx_full, rx_empty;
    logic [7:0]       rx_head;
    logic [7:0]       tx_cnt8, rx_cnt8;
    logic [NUM_EVT-1:0] evt_set, evt_clr, evt_flags;
    logic [31:0]      status_w;

    // write / read decode
    always_comb begin
        wr_ctrl = reg_wr && (reg_addr == ADR_CTRL);
        wr_stat = reg_wr && (reg_addr == ADR_STAT);
        wr_ien  = reg_wr && (reg_addr == ADR_IEN);
        wr_wm   = reg_wr && (reg_addr == ADR_WMARK);
        wr_tx   = reg_wr && (reg_addr == ADR_TXCMD);
        rd_rx   = reg_rd && (reg_addr == ADR_RXDAT);
    end

    // next-state of the configuration registers
    always_comb begin
        r_d       = r_q;
        r_d.mbusy = eng_mbusy;
        r_d.bbusy = eng_bbusy;
        if (wr_ctrl) begin
            r_d.en   = reg_wdata[CT_EN];
            r_d.srst = reg_wdata[CT_SRST];
        end
        if (wr_ien) begin
            r_d.ien = reg_wdata & IEN_MASK;
        end
        if (r_q.srst) begin
            r_d.tx_wm = '0;
            r_d.rx_wm = '0;
        end else if (wr_wm) begin
            r_d.tx_wm = reg_wdata[7:0];
            r_d.rx_wm = reg_wdata[23:16];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // FIFO control strobes
    always_comb begin
        tx_flush = r_q.srst || (wr_ctrl && reg_wdata[CT_TXFL]);
        rx_flush = r_q.srst || (wr_ctrl && reg_wdata[CT_RXFL]);
        tx_push  = wr_tx && !r_q.srst;
    end

    i2cf_fifo #(.W(CMD_W), .AW(TX_AW)) u_txq (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (tx_flush),
        .push  (tx_push),
        .pop   (eng_tx_pop),
        .wdata (reg_wdata[CMD_W-1:0]),
        .rdata (eng_tx_cmd),
        .count (tx_count),
        .full  (tx_full),
        .empty (tx_empty)
    );

    i2cf_fifo #(.W(8), .AW(RX_AW)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (rx_flush),
        .push  (eng_rx_push),
        .pop   (rd_rx),
        .wdata (eng_rx_byte),
        .rdata (rx_head),
        .count (rx_count),
        .full  (rx_full),
        .empty (rx_empty)
    );

    // sticky events: index 0 stop, 1 nack, 2 arbitration
    always_comb begin
        evt_set = {eng_arb_evt, eng_nack_evt, eng_stop_evt};
        evt_clr = wr_stat ? reg_wdata[ST_ARB:ST_STOP] : '0;
    end

    i2cf_events #(.N(NUM_EVT)) u_evt (
        .clk   (clk),
        .rst_n (rst_n),
        .wipe  (r_q.srst),
        .set   (evt_set),
        .clr   (evt_clr),
        .flags (evt_flags)
    );

    // status word assembly
    always_comb begin
        tx_cnt8  = 8'(tx_count);
        rx_cnt8  = 8'(rx_count);
        status_w = '0;
        status_w[ST_TXREQ]        = (tx_cnt8 <= r_q.tx_wm);
        status_w[ST_RXRDY]        = (rx_cnt8 > r_q.rx_wm);
        status_w[ST_ARB:ST_STOP]  = evt_flags;
        status_w[ST_MBUSY]        = r_q.mbusy;
        status_w[ST_BBUSY]        = r_q.bbusy;
    end

    // read mux
    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADR_CAPS:  reg_rdata = {20'b0, 4'(RX_AW), 4'b0, 4'(TX_AW)};
            ADR_CTRL:  reg_rdata = {30'b0, r_q.srst, r_q.en};
            ADR_STAT:  reg_rdata = status_w;
            ADR_IEN:   reg_rdata = r_q.ien;
            ADR_WMARK: reg_rdata = {8'b0, r_q.rx_wm, 8'b0, r_q.tx_wm};
            ADR_FILL:  reg_rdata = {8'b0, rx_cnt8, 8'b0, tx_cnt8};
            ADR_RXDAT: reg_rdata = {17'b0, rx_empty, 6'b0, (rx_empty ? 8'h00 : rx_head)};
            default:   reg_rdata = '0;
        endcase
    end

    assign master_en    = r_q.en;
    assign eng_tx_valid = !tx_empty;
    assign irq          = |(status_w & r_q.ien);

    p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.ien == '0) |-> !irq);
    p_rx_empty_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rx && rx_empty && !eng_rx_push) |=> rx_empty);
    p_busy_track_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (status_w[ST_MBUSY] == $past(eng_mbusy)));
    p_srst_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.srst |=> (tx_empty && rx_empty));
    p_rx_full_keep_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && eng_rx_push && !rd_rx && !rx_flush) |=> rx_full);
endmodule

// File: tb/tb_i2c_cmd_regfront.sv
module tb_i2c_cmd_regfront;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        master_en, eng_tx_valid, irq;
    logic [10:0] eng_tx_cmd;
    logic        eng_tx_pop = 0, eng_rx_push = 0;
    logic [7:0]  eng_rx_byte = '0;
    logic        eng_stop_evt = 0, eng_nack_evt = 0, eng_arb_evt = 0;
    logic        eng_mbusy = 0, eng_bbusy = 0;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    logic [10:0] txq[$];
    logic [7:0]  rxq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_cmd_regfront dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .master_en(master_en), .eng_tx_valid(eng_tx_valid), .eng_tx_cmd(eng_tx_cmd),
        .eng_tx_pop(eng_tx_pop), .eng_rx_push(eng_rx_push), .eng_rx_byte(eng_rx_byte),
        .eng_stop_evt(eng_stop_evt), .eng_nack_evt(eng_nack_evt), .eng_arb_evt(eng_arb_evt),
        .eng_mbusy(eng_mbusy), .eng_bbusy(eng_bbusy), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    // driver: queue a transmit command and predict whether it is kept
    task automatic send_cmd(input logic [10:0] c, input bit expect_kept);
        if (expect_kept) txq.push_back(c);
        wr(8'h18, {21'b0, c});
    endtask

    task automatic eng_pop();
        @(negedge clk); eng_tx_pop = 1'b1;
        @(negedge clk); eng_tx_pop = 1'b0;
    endtask

    task automatic rx_push(input logic [7:0] b, input bit expect_kept);
        if (expect_kept) rxq.push_back(b);
        @(negedge clk); eng_rx_push = 1'b1; eng_rx_byte = b;
        @(negedge clk); eng_rx_push = 1'b0;
    endtask

    task automatic rx_read_expect();
        logic [7:0] e;
        e = rxq.pop_front();
        rd_chk("R5 rx byte order", 8'h1C, {24'b0, e});
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: eng_stop_evt = 1'b1;
            1: eng_nack_evt = 1'b1;
            default: eng_arb_evt = 1'b1;
        endcase
        @(negedge clk);
        eng_stop_evt = 1'b0; eng_nack_evt = 1'b0; eng_arb_evt = 1'b0;
    endtask

    // monitor: compare each word the engine takes against the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (rst_n && eng_tx_pop && eng_tx_valid) begin
                if (txq.size() == 0) begin
                    chk("R3 unexpected tx word", {21'b0, eng_tx_cmd}, 32'hFFFF_FFFF);
                end else begin
                    logic [10:0] e;
                    e = txq.pop_front();
                    chk("R3 tx word order", {21'b0, eng_tx_cmd}, {21'b0, e});
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2 reset state, R1 capability word
        rd_chk("R1 caps word", 8'h00, 32'h0000_0202);
        rd_chk("R2 reset status", 8'h08, 32'h0000_0001);
        rd_chk("R2 reset fill", 8'h14, 32'h0);
        rd_chk("R2 reset ien", 8'h0C, 32'h0);
        chk("R2 reset irq", {31'b0, irq}, 32'h0);

        // R11 master enable
        wr(8'h04, 32'h1);
        chk("R11 master_en", {31'b0, master_en}, 32'h1);
        rd_chk("R11 ctrl readback", 8'h04, 32'h1);

        // R3/R4 transmit path with watermark 1
        wr(8'h10, 32'h0000_0001);
        rd_chk("R4 wmark readback", 8'h10, 32'h0000_0001);
        send_cmd(11'h4A0, 1);
        rd_chk("R4 txreq count1 wm1", 8'h08, 32'h0000_0001);
        send_cmd(11'h055, 1);
        rd_chk("R4 txreq count2 wm1", 8'h08, 32'h0000_0000);
        send_cmd(11'h0AA, 1);
        send_cmd(11'h1FF, 1);
        send_cmd(11'h7EE, 0); // full: dropped
        rd_chk("R3 tx count full", 8'h14, 32'h0000_0004);
        eng_pop();
        eng_pop();
        rd_chk("R6 tx count bits", 8'h14, 32'h0000_0002);
        eng_pop();
        rd_chk("R4 txreq back at wm", 8'h08, 32'h0000_0001);
        eng_pop();
        chk("R3 tx drained valid", {31'b0, eng_tx_valid}, 32'h0);
        chk("R3 scoreboard empty", txq.size(), 32'h0);

        // R6/R12 receive path with watermark 1
        wr(8'h10, 32'h0001_0000);
        rx_push(8'h11, 1);
        rd_chk("R6 rxrdy count1 wm1", 8'h08, 32'h0000_0001);
        rx_push(8'h22, 1);
        rd_chk("R6 rxrdy count2 wm1", 8'h08, 32'h0000_0003);
        rd_chk("R6 rx fill bits", 8'h14, 32'h0002_0000);
        rx_push(8'h33, 1);
        rx_push(8'h44, 1);
        rx_push(8'h55, 0); // full: dropped
        rd_chk("R12 rx count full", 8'h14, 32'h0004_0000);
        rx_read_expect();
        rx_read_expect();
        rx_read_expect();
        rd_chk("R6 rxrdy off at wm", 8'h08, 32'h0000_0001);
        rx_read_expect();
        // R5 empty read marker and no pop
        rd_chk("R5 empty read marker", 8'h1C, 32'h0000_4000);
        rx_push(8'h66, 1);
        rx_read_expect();
        rd_chk("R5 empty again", 8'h1C, 32'h0000_4000);

        // R7 sticky events
        pulse(0);
        pulse(1);
        rd_chk("R7 stop+nack set", 8'h08, 32'h0000_0601);
        wr(8'h08, 32'h0);
        rd_chk("R7 zero write keeps", 8'h08, 32'h0000_0601);
        wr(8'h08, 32'h0000_0200);
        rd_chk("R7 clear stop only", 8'h08, 32'h0000_0401);
        wr(8'h08, 32'h0000_7F00);
        rd_chk("R7 clear all", 8'h08, 32'h0000_0001);

        // R8 busy levels
        @(negedge clk); eng_mbusy = 1'b1; eng_bbusy = 1'b1;
        @(negedge clk);
        rd_chk("R8 busy bits", 8'h08, 32'h0300_0001);
        @(negedge clk); eng_mbusy = 1'b0; eng_bbusy = 1'b0;
        @(negedge clk);
        rd_chk("R8 busy cleared", 8'h08, 32'h0000_0001);

        // R9 interrupt
        wr(8'h0C, 32'hFFFF_FFFF);
        rd_chk("R9 ien readback", 8'h0C, 32'h0300_0E03);
        wr(8'h0C, 32'h0000_0400);
        chk("R9 irq masked txreq", {31'b0, irq}, 32'h0);
        pulse(1);
        chk("R9 irq on nack", {31'b0, irq}, 32'h1);
        wr(8'h08, 32'h0000_7F00);
        chk("R9 irq after clear", {31'b0, irq}, 32'h0);
        wr(8'h0C, 32'h0000_0001);
        chk("R9 irq on txreq", {31'b0, irq}, 32'h1);
        wr(8'h0C, 32'h0);

        // R10 flushes
        send_cmd(11'h011, 0);
        send_cmd(11'h022, 0);
        rx_push(8'h77, 0);
        wr(8'h04, 32'h0000_0101);
        rd_chk("R10 tx flushed", 8'h14, 32'h0001_0000);
        rd_chk("R10 flush bit reads 0", 8'h04, 32'h1);
        wr(8'h04, 32'h0000_0201);
        rd_chk("R10 rx flushed", 8'h14, 32'h0);

        // R11 software reset
        send_cmd(11'h033, 0);
        pulse(2);
        wr(8'h10, 32'h0003_0003);
        wr(8'h04, 32'h3);
        @(negedge clk);
        rd_chk("R11 srst fill", 8'h14, 32'h0);
        rd_chk("R11 srst events", 8'h08, 32'h0000_0001);
        rd_chk("R11 srst wmarks", 8'h10, 32'h0);
        chk("R11 master_en in srst", {31'b0, master_en}, 32'h1);
        send_cmd(11'h044, 0);
        rd_chk("R11 tx write dropped", 8'h14, 32'h0);
        wr(8'h04, 32'h1);
        send_cmd(11'h055, 1);
        rd_chk("R11 tx after srst", 8'h14, 32'h0000_0001);
        eng_pop();
        chk("R3 final scoreboard", txq.size(), 32'h0);

        repeat (3) @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule